// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sequences the two gate-enable signals of a complementary switch pair (an upper, high-side switch and a lower, low-side switch). It receives a PWM level that has already been decoded to a digital bit, a flag that says the PWM source is floating, an enable, and two fault inputs: supply undervoltage and over-temperature. Two feedback bits report when each gate has actually fallen below its turn-off threshold. The block never lets both outputs be high at the same time. An output is switched on only after the opposite gate has been reported low and a further fixed number of clock cycles has passed. Because this rule does not depend on which way the load current flows, the same sequencer serves buck, boost or bridge stages.

Any fault, a low enable or a floating PWM source turns both outputs off. While a fault is present the block asserts an open-drain style pulldown flag, so a controller sharing the enable line can tell that the stage is not ready. If a turn-off report does not arrive within a timeout, a sticky error flag is set and both outputs stay off until reset. A turn-on request that has been accepted is always completed, so a PWM high pulse lasting one clock still reaches the upper output, and the dead-time rule applies on both of its edges.

Top module: `deadtime_gate_seq`

## Requirements
- R1: `hs_gate` and `ls_gate` are never both 1 in the same cycle.
- R2: An output rises only after the opposite sensed-low input (`ls_low_sns` for `hs_gate`, `hs_low_sns` for `ls_gate`) has been sampled at 1 while waiting. The rising edge comes exactly `HOLD_CYC` clock edges after the edge that sampled it.
- R3: With `run_en`=1, no fault and `pwm_float`=0, a steady `pwm_lvl`=1 settles to `hs_gate`=1, `ls_gate`=0, and a steady `pwm_lvl`=0 settles to `ls_gate`=1, `hs_gate`=0.
- R4: When `run_en` is sampled at 0, both outputs are 0 from the next clock edge on, whatever `pwm_lvl` is.
- R5: When `pwm_float` is sampled at 1, both outputs are 0 from the next clock edge on, and `pwm_lvl` has no effect while the flag stays at 1.
- R6: When `uv_flt` or `ot_flt` is sampled at 1, both outputs are 0 and `pg_pull` is 1 after the next edge. `pg_pull` returns to 0 on the first edge that samples both faults at 0.
- R7: While reset is applied and after it is released, both outputs are 0 and `sense_err` is 0. `pg_pull` stays 1 until the first edge after reset that samples no fault.
- R8: A `pwm_lvl` high pulse lasting one clock, arriving while the lower output is on, produces exactly one `hs_gate` pulse. The lower output then comes back under the R2 rule.
- R9: If the awaited sensed-low input stays 0 for `TMO_CYC` sampled cycles, `sense_err` becomes 1 and stays 1 until reset, and both outputs stay 0.
- R10: When `run_en` and `pwm_lvl` switch together, the lower output never turns on and the upper output alone follows the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_lvl | input | 1 | Decoded PWM level, 1 = upper switch requested |
| pwm_float | input | 1 | PWM source is in its high-impedance window |
| run_en | input | 1 | Enable, 1 = follow the PWM input |
| uv_flt | input | 1 | Supply undervoltage fault |
| ot_flt | input | 1 | Over-temperature fault |
| hs_low_sns | input | 1 | Upper gate sensed below its turn-off threshold |
| ls_low_sns | input | 1 | Lower gate sensed below its turn-off threshold |
| hs_gate | output | 1 | Upper gate enable |
| ls_gate | output | 1 | Lower gate enable |
| pg_pull | output | 1 | Pulldown request for the shared enable/ready line |
| sense_err | output | 1 | Sticky turn-off report timeout |

## Verification
Turn-off responses (enable low, floating PWM, faults) and the `pg_pull` update appear on the edge after the one that samples the cause, so the bench drives inputs on falling edges and reads the result on the next falling edge. Turn-on is due `HOLD_CYC` edges after the edge that samples the opposite sensed-low bit. The bench makes that bit from the observed gates with a fixed fall latency of `FALL` cycles, so the all-off gap before the upper gate rises is `FALL+HOLD_CYC` cycles. A behavioural reference model steps on every rising edge and is compared with all outputs on every falling edge. The timeout error is due `TMO_CYC` sampled cycles after the wait begins.

// File: rtl/dgs_pkg.sv
// Shared types for the dead-time gate sequencer.
// Assumes: two-valued encodings only; no other block depends on the codes.
package dgs_pkg;

    // Which output the inputs currently ask for.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_HI   = 2'd1,
        TGT_LO   = 2'd2
    } tgt_t;

    // Sequencer phases.
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_WAIT_HS = 3'd1,
        ST_HS_ON   = 3'd2,
        ST_WAIT_LS = 3'd3,
        ST_LS_ON   = 3'd4,
        ST_ERR     = 3'd5
    } seq_t;

    // Number of switch legs handled by the gap timers.
    localparam int unsigned NLEG = 2;

endpackage

// File: rtl/dgs_fault_mon.sv
// Request decoder and ready-flag driver.
// Turns enable, floating flag, faults and PWM level into one target request.
// Registers the pulldown flag, which reset forces high.
// Assumes all inputs are already synchronous to clk.
module dgs_fault_mon
    import dgs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_lvl,
    input  logic pwm_float,
    input  logic run_en,
    input  logic uv_flt,
    input  logic ot_flt,
    output tgt_t tgt,
    output logic pg_pull
);

    logic fault_any;
    logic run_ok;

    // Any fault, a disabled stage or a floating source suppresses both gates.
    always_comb begin
        fault_any = uv_flt | ot_flt;
        run_ok    = run_en & ~fault_any & ~pwm_float;
        if (!run_ok)
            tgt = TGT_NONE;
        else if (pwm_lvl)
            tgt = TGT_HI;
        else
            tgt = TGT_LO;
    end

    // Pulldown flag follows the fault inputs one edge later; reset holds it high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pg_pull <= 1'b1;
        else
            pg_pull <= fault_any;
    end

    AST_PG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flt || ot_flt) |=> pg_pull); // R6
    AST_PG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!uv_flt && !ot_flt) |=> !pg_pull); // R6

endmodule

// File: rtl/dgs_gap_timer.sv
// Turn-on gap timer for one leg.
// Waits for the opposite gate's sensed-low bit, then counts HOLD_CYC edges.
// Flags a timeout when the bit stays low for TMO_CYC sampled cycles.
// Assumes HOLD_CYC >= 1 and TMO_CYC >= 1; 'clear' wins over 'active'.
module dgs_gap_timer #(
    parameter int unsigned HOLD_CYC = 3,
    parameter int unsigned TMO_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic opp_low,
    output logic done,
    output logic tmo
);

    localparam int unsigned HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam int unsigned TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYC - 1);

    logic          seen_q;
    logic [HW-1:0] hold_q;
    logic [TW-1:0] wait_q;

    // Completion and timeout are decoded from the counters and the live sense bit.
    always_comb begin
        done = seen_q && (hold_q == HOLD_LAST);
        tmo  = !seen_q && !opp_low && (wait_q == TMO_LAST);
    end

    // Two-phase count: wait for the sense report, then the fixed hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seen_q <= 1'b0;
            hold_q <= '0;
            wait_q <= '0;
        end else if (active) begin
            if (!seen_q) begin
                if (opp_low)
                    seen_q <= 1'b1;
                else if (wait_q != TMO_LAST)
                    wait_q <= wait_q + 1'b1;
            end else if (hold_q != HOLD_LAST) begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    AST_HOLD_NEEDS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clear && !seen_q && !opp_low) |=> (hold_q == '0)); // R2

endmodule

// File: rtl/dgs_fsm.sv
// Gate sequencing state machine.
// Accepts a turn-on request, holds it until the leg's gap timer completes, and drives
// registered gate outputs. A timeout moves it to a sticky error state.
// Assumes one gap timer per leg: index 0 gates the upper output, index 1 the lower.
module dgs_fsm
    import dgs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  tgt_t            tgt,
    input  logic [NLEG-1:0] gap_done,
    input  logic [NLEG-1:0] gap_tmo,
    output logic [NLEG-1:0] gap_clr,
    output logic [NLEG-1:0] gap_act,
    output logic            hs_q,
    output logic            ls_q,
    output logic            err_q
);

    seq_t st_q;
    seq_t st_d;

    // Next phase: error is sticky, no request aborts, accepted requests complete.
    always_comb begin
        st_d = st_q;
        if (st_q == ST_ERR) begin
            st_d = ST_ERR;
        end else if (tgt == TGT_NONE) begin
            st_d = ST_OFF;
        end else begin
            case (st_q)
                ST_OFF:     st_d = (tgt == TGT_HI) ? ST_WAIT_HS : ST_WAIT_LS;
                ST_WAIT_HS: begin
                    if (gap_tmo[0])       st_d = ST_ERR;
                    else if (gap_done[0]) st_d = ST_HS_ON;
                end
                ST_HS_ON:   if (tgt == TGT_LO) st_d = ST_WAIT_LS;
                ST_WAIT_LS: begin
                    if (gap_tmo[1])       st_d = ST_ERR;
                    else if (gap_done[1]) st_d = ST_LS_ON;
                end
                ST_LS_ON:   if (tgt == TGT_HI) st_d = ST_WAIT_HS;
                default:    st_d = ST_ERR;
            endcase
        end
    end

    // Timer controls: clear on entering a wait phase, count while in it.
    always_comb begin
        gap_clr[0] = (st_d == ST_WAIT_HS) && (st_q != ST_WAIT_HS);
        gap_clr[1] = (st_d == ST_WAIT_LS) && (st_q != ST_WAIT_LS);
        gap_act[0] = (st_q == ST_WAIT_HS);
        gap_act[1] = (st_q == ST_WAIT_LS);
    end

    // Phase register and glitch-free registered gate outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            hs_q  <= 1'b0;
            ls_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            hs_q  <= (st_d == ST_HS_ON);
            ls_q  <= (st_d == ST_LS_ON);
            err_q <= (st_d == ST_ERR);
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_q && ls_q)); // R1
    AST_HS_RISE_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_q) |-> $past(!ls_q)); // R2
    AST_LS_RISE_AFTER_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_q) |-> $past(!hs_q)); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> (err_q && !hs_q && !ls_q)); // R9

endmodule

// File: rtl/deadtime_gate_seq.sv
// Adaptive dead-time gate sequencer for a complementary switch pair.
// Upper/lower gate enables never overlap; each turn-on waits for the opposite
// gate's sensed-low report plus HOLD_CYC cycles. Faults, enable low and a floating
// PWM source force both gates off.
// Assumes every input is synchronous to clk.
module deadtime_gate_seq #(
    parameter int unsigned HOLD_CYC = 3,
    parameter int unsigned TMO_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_lvl,
    input  logic pwm_float,
    input  logic run_en,
    input  logic uv_flt,
    input  logic ot_flt,
    input  logic hs_low_sns,
    input  logic ls_low_sns,
    output logic hs_gate,
    output logic ls_gate,
    output logic pg_pull,
    output logic sense_err
);

    import dgs_pkg::*;

    tgt_t            tgt;
    logic [NLEG-1:0] gap_clr;
    logic [NLEG-1:0] gap_act;
    logic [NLEG-1:0] gap_done;
    logic [NLEG-1:0] gap_tmo;
    logic [NLEG-1:0] opp_low;

    // Leg 0 (upper turn-on) watches the lower gate; leg 1 watches the upper gate.
    assign opp_low = {hs_low_sns, ls_low_sns};

    dgs_fault_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_lvl   (pwm_lvl),
        .pwm_float (pwm_float),
        .run_en    (run_en),
        .uv_flt    (uv_flt),
        .ot_flt    (ot_flt),
        .tgt       (tgt),
        .pg_pull   (pg_pull)
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        dgs_gap_timer #(
            .HOLD_CYC (HOLD_CYC),
            .TMO_CYC  (TMO_CYC)
        ) u_gap (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (gap_clr[g]),
            .active  (gap_act[g]),
            .opp_low (opp_low[g]),
            .done    (gap_done[g]),
            .tmo     (gap_tmo[g])
        );
    end

    dgs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt      (tgt),
        .gap_done (gap_done),
        .gap_tmo  (gap_tmo),
        .gap_clr  (gap_clr),
        .gap_act  (gap_act),
        .hs_q     (hs_gate),
        .ls_q     (ls_gate),
        .err_q    (sense_err)
    );

    AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!hs_gate && !ls_gate)); // R4
    AST_FLOAT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_float |=> (!hs_gate && !ls_gate)); // R5
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flt || ot_flt) |=> (!hs_gate && !ls_gate)); // R6
    AST_HS_NEEDS_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> $past(!ls_gate, 2)); // R2

endmodule

// File: tb/sim_deadtime_gate_seq.sv
module sim_deadtime_gate_seq;

    localparam int HOLD = 3;
    localparam int TMO  = 16;
    localparam int FALL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_lvl = 1'b0, pwm_float = 1'b0, run_en = 1'b0, uv_flt = 1'b0, ot_flt = 1'b0;
    logic hs_low_sns = 1'b1, ls_low_sns = 1'b1;
    logic hs_gate, ls_gate, pg_pull, sense_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit stuck_hs = 1'b0;
    int hs_zero = FALL;
    int ls_zero = FALL;

    // reference model state: 0 off, 1 wait upper, 2 upper on, 3 wait lower, 4 lower on, 5 error
    int m_mode = 0, m_seen = 0, m_hold = 0, m_wait = 0;
    bit m_pg = 1'b1;

    always #10 clk = ~clk;

    deadtime_gate_seq #(.HOLD_CYC(HOLD), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .pwm_float(pwm_float),
        .run_en(run_en), .uv_flt(uv_flt), .ot_flt(ot_flt),
        .hs_low_sns(hs_low_sns), .ls_low_sns(ls_low_sns),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .pg_pull(pg_pull), .sense_err(sense_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Gate fall model: sense bit goes high after FALL low samples of the gate.
    always @(negedge clk) begin
        hs_zero = hs_gate ? 0 : (hs_zero < FALL ? hs_zero + 1 : FALL);
        ls_zero = ls_gate ? 0 : (ls_zero < FALL ? ls_zero + 1 : FALL);
        hs_low_sns <= stuck_hs ? 1'b0 : (hs_zero >= FALL);
        ls_low_sns <= (ls_zero >= FALL);
        cyc++;
    end

    // Behavioural reference stepped on every rising edge.
    always @(posedge clk) begin
        int want;
        bit sns;
        if (!rst_n) begin
            m_mode = 0; m_seen = 0; m_hold = 0; m_wait = 0; m_pg = 1'b1;
        end else begin
            m_pg = uv_flt | ot_flt;
            if (!run_en || uv_flt || ot_flt || pwm_float) want = 0;
            else want = pwm_lvl ? 1 : 2;
            if (m_mode == 5) m_mode = 5;
            else if (want == 0) m_mode = 0;
            else if (m_mode == 1 || m_mode == 3) begin
                sns = (m_mode == 1) ? ls_low_sns : hs_low_sns;
                if (m_seen == 0) begin
                    if (sns) m_seen = 1;
                    else if (m_wait == TMO - 1) m_mode = 5;
                    else m_wait++;
                end else if (m_hold == HOLD - 1) m_mode = m_mode + 1;
                else m_hold++;
            end else begin
                int nxt;
                nxt = m_mode;
                if (m_mode == 0) nxt = (want == 1) ? 1 : 3;
                else if (m_mode == 2 && want == 2) nxt = 3;
                else if (m_mode == 4 && want == 1) nxt = 1;
                if (nxt != m_mode) begin
                    m_seen = 0; m_hold = 0; m_wait = 0;
                end
                m_mode = nxt;
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(hs_gate == (m_mode == 2), "R3 upper gate vs model", hs_gate, m_mode == 2);
            chk(ls_gate == (m_mode == 4), "R3 lower gate vs model", ls_gate, m_mode == 4);
            chk(pg_pull == m_pg, "R6 pulldown vs model", pg_pull, m_pg);
            chk(sense_err == (m_mode == 5), "R9 error flag vs model", sense_err, m_mode == 5);
            chk(!(hs_gate && ls_gate), "R1 overlap", hs_gate + ls_gate, 1);
        end
    end

    initial begin
        while (cyc < 20000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int gap, hi_cnt, rises;
        bit prev;
        step(3);
        chk(!hs_gate && !ls_gate && !sense_err && pg_pull, "R7 reset state",
            {hs_gate, ls_gate, sense_err, pg_pull}, 1);
        rst_n = 1'b1;
        step(1);
        cmp_on = 1'b1;
        chk(!pg_pull, "R7 pulldown released after first clean cycle", pg_pull, 0);

        // R3: lower on when enabled and PWM low.
        run_en = 1'b1;
        step(20);
        chk(ls_gate && !hs_gate, "R3 lower steady", ls_gate, 1);

        // R2: measure all-off gap before the upper gate rises.
        pwm_lvl = 1'b1;
        gap = 0;
        do begin step(1); gap++; end while (!hs_gate && gap < 50);
        chk(gap == FALL + HOLD + 1, "R2 turn-on gap", gap, FALL + HOLD + 1);
        step(10);
        chk(hs_gate && !ls_gate, "R3 upper steady", hs_gate, 1);

        // A few ordinary periods.
        for (int p = 0; p < 4; p++) begin
            pwm_lvl = 1'b0; step(12 + p);
            pwm_lvl = 1'b1; step(14 - p);
        end
        pwm_lvl = 1'b0; step(20);

        // R8: one-clock PWM pulse while lower is on.
        pwm_lvl = 1'b1; step(1); pwm_lvl = 1'b0;
        hi_cnt = 0; rises = 0; prev = 1'b0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (hs_gate) hi_cnt++;
            if (hs_gate && !prev) rises++;
            prev = hs_gate;
        end
        chk(rises == 1, "R8 narrow pulse passed once", rises, 1);
        chk(hi_cnt == 1, "R8 narrow pulse width", hi_cnt, 1);
        chk(ls_gate, "R8 lower restored", ls_gate, 1);

        // R4: enable low with upper on.
        pwm_lvl = 1'b1; step(15);
        run_en = 1'b0; step(1);
        chk(!hs_gate && !ls_gate, "R4 enable low turns off", hs_gate + ls_gate, 0);
        pwm_lvl = 1'b0; step(5);
        chk(!hs_gate && !ls_gate, "R4 stays off with PWM low", hs_gate + ls_gate, 0);

        // R10: enable and PWM pulsed together.
        hi_cnt = 0;
        rises = 0;
        for (int p = 0; p < 3; p++) begin
            run_en = 1'b1; pwm_lvl = 1'b1;
            for (int i = 0; i < 12; i++) begin step(1); if (ls_gate) hi_cnt++; if (hs_gate) rises++; end
            run_en = 1'b0; pwm_lvl = 1'b0;
            for (int i = 0; i < 12; i++) begin step(1); if (ls_gate) hi_cnt++; end
        end
        chk(hi_cnt == 0, "R10 lower never on", hi_cnt, 0);
        chk(rises > 0, "R10 upper follows pulses", rises, 1);

        // R5: floating source.
        run_en = 1'b1; step(20);
        pwm_float = 1'b1; step(1);
        chk(!hs_gate && !ls_gate, "R5 float turns off", hs_gate + ls_gate, 0);
        hi_cnt = 0;
        for (int i = 0; i < 8; i++) begin pwm_lvl = ~pwm_lvl; step(1); hi_cnt += hs_gate + ls_gate; end
        chk(hi_cnt == 0, "R5 PWM ignored while floating", hi_cnt, 0);
        pwm_float = 1'b0; pwm_lvl = 1'b1; step(20);

        // R6: undervoltage then over-temperature.
        uv_flt = 1'b1; step(1);
        chk(pg_pull && !hs_gate && !ls_gate, "R6 undervoltage", {pg_pull, hs_gate, ls_gate}, 4);
        uv_flt = 1'b0; step(1);
        chk(!pg_pull, "R6 pulldown released", pg_pull, 0);
        step(15);
        ot_flt = 1'b1; step(1);
        chk(pg_pull && !hs_gate && !ls_gate, "R6 over-temperature", {pg_pull, hs_gate, ls_gate}, 4);
        step(4);
        ot_flt = 1'b0; step(1);
        chk(!pg_pull, "R6 pulldown released after heat", pg_pull, 0);
        step(15);

        // R9: upper sense stuck low, request the lower gate.
        stuck_hs = 1'b1;
        pwm_lvl = 1'b0; step(TMO + 6);
        chk(sense_err && !ls_gate && !hs_gate, "R9 timeout error", sense_err, 1);
        stuck_hs = 1'b0;
        pwm_lvl = 1'b1; step(10); pwm_lvl = 1'b0; step(10);
        chk(sense_err && !ls_gate && !hs_gate, "R9 error sticky", sense_err, 1);

        // R7: reset clears the error.
        cmp_on = 1'b0;
        rst_n = 1'b0; step(2);
        rst_n = 1'b1; step(1);
        cmp_on = 1'b1;
        chk(!sense_err, "R7 error cleared by reset", sense_err, 0);
        step(20);
        chk(ls_gate, "R3 lower again after reset", ls_gate, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule